// File: doc/BRIEF.md
# Direct-Mapped Byte Cache with Write-Through

This block is a small direct-mapped cache between a byte-wide processor port and a byte-wide main-memory port. Every line has a valid flag, a tag and a block of data bytes. The processor gives a byte address. The cache splits it into a tag, a line index and a byte offset, and checks the one line that the index selects.

When a read hits, the cache returns the byte without any memory traffic. When a read misses, the processor stays stalled while the cache fetches the whole block, one byte per memory acknowledge, and overwrites the indexed line. The cache then re-runs the lookup, which now hits. Every write goes through to memory as a single-byte write, and the processor waits for that write to be acknowledged. A static configuration input decides what a write miss does. With allocation on, the block is fetched first and the byte is merged into the line. With allocation off, only memory is written.

The processor hands over one request in a cycle where `cpu_ready` is high. Completion is a one-cycle `cpu_done` pulse.

Top module: `dm_cache`

## Requirements
- R1: The byte address splits into three fields. The offset is bits [1:0], the line index is bits [3:2] and the tag is bits [15:4]. Blocks with different index values occupy different lines; for example, byte 0x38 (block 14) uses line 2 with tag 3.
- R2: Reset clears every valid flag, so the first access to any block misses. After reset `cpu_ready` is 1 and both `cpu_done` and `mem_req` are 0.
- R3: A read hit returns the addressed byte on `cpu_rdata` with `cpu_done`, and makes no memory request.
- R4: A read miss issues exactly 4 read requests (`mem_we`=0), at the block base plus offsets 0, 1, 2 and 3 in that order. The cache then completes the access with the addressed byte.
- R5: A block that maps to an occupied line replaces it unconditionally. The evicted block misses on its next access.
- R6: Every write issues exactly one memory write (`mem_we`=1) at the full byte address with `cpu_wdata`. `cpu_done` is not raised before that write is acknowledged.
- R7: A write hit also updates the cached byte under both policies, so a following read of that byte hits and returns the new value.
- R8: With `alloc_on_write`=1, a write miss first refills the line with 4 reads, then merges the byte and writes it through. Later reads of that block hit.
- R9: With `alloc_on_write`=0, a write miss issues no reads and changes no line. The block previously held in that line still hits, and the written block still misses.
- R10: `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`. `cpu_ready` is low from acceptance until completion.
- R11: `cpu_done` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_on_write | input | 1 | 1: fetch the block on a write miss; 0: write memory only |
| cpu_req | input | 1 | Request, taken when cpu_ready is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | Cache idle, can accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid with cpu_done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory acknowledge, one per byte |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ack |

## Verification
The bench targets blocks that share a line index but differ in tag. A design that compared only the index would return stale bytes from the evicted block. It also checks that a write miss with allocation off leaves the line alone. A design that allocated anyway would show refill reads, and would then miss on the block that was held before.

The bench logs the refill addresses. A design that counted beats wrongly, or started the refill at the requested offset, would fetch the wrong bytes. It also reads back after a write hit. A design that only wrote memory would return the old byte on a hit. Finally, it checks that a write-allocate miss ends with the merged byte rather than the fetched one.

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int ADDR_W      = 16,
  parameter int LINES       = 4,
  parameter int BLOCK_BYTES = 4,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_on_write,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FILL, S_WRITE} st_t;

  st_t               st;
  logic [ADDR_W-1:0] a_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;
  logic [OFF_W-1:0]  beat_q;
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES][BLOCK_BYTES];
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  wire [TAG_W-1:0] a_tag = a_q[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] a_idx = a_q[OFF_W +: IDX_W];
  wire [OFF_W-1:0] a_off = a_q[OFF_W-1:0];
  wire             hit   = valid_q[a_idx] && (tag_q[a_idx] == a_tag);
  wire             last_beat = (beat_q == OFF_W'(BLOCK_BYTES - 1));

  assign cpu_ready = (st == S_IDLE);
  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;
  assign mem_req   = (st == S_FILL) || (st == S_WRITE);
  assign mem_we    = (st == S_WRITE);
  assign mem_addr  = (st == S_WRITE) ? a_q : {a_tag, a_idx, beat_q};
  assign mem_wdata = wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      a_q     <= '0;
      we_q    <= 1'b0;
      wd_q    <= '0;
      beat_q  <= '0;
      valid_q <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (cpu_req) begin
          a_q  <= cpu_addr;
          we_q <= cpu_we;
          wd_q <= cpu_wdata;
          st   <= S_LOOK;
        end
        S_LOOK: begin
          beat_q <= '0;
          if (hit) begin
            if (we_q) st <= S_WRITE;
            else begin
              rdata_q <= data_q[a_idx][a_off];
              done_q  <= 1'b1;
              st      <= S_IDLE;
            end
          end else if (we_q && !alloc_on_write) st <= S_WRITE;
          else st <= S_FILL;
        end
        S_FILL: if (mem_ack) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            valid_q[a_idx] <= 1'b1;
            tag_q[a_idx]   <= a_tag;
            st             <= S_LOOK;
          end
        end
        S_WRITE: if (mem_ack) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && mem_ack)
      data_q[a_idx][beat_q] <= mem_rdata;
    else if (st == S_LOOK && we_q && hit)
      data_q[a_idx][a_off] <= wd_q;
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  assert_fill_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) && !mem_we |-> mem_addr[OFF_W-1:0] == '0);

  assert_fill_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack && mem_addr[OFF_W-1:0] != OFF_W'(BLOCK_BYTES - 1)
    |=> mem_req && !mem_we && mem_addr == $past(mem_addr) + 1'b1);

  assert_write_keeps_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |=> $stable(valid_q));

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);
endmodule

// File: tb/sim_dm_cache.sv
module sim_dm_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_on_write = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic cpu_ready, cpu_done;
  logic [7:0] cpu_rdata;
  logic mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic mem_ack = 1'b0;
  logic [7:0] mem_rdata = '0;

  always #10 clk = ~clk;

  dm_cache u0 (.clk(clk), .rst_n(rst_n), .alloc_on_write(alloc_on_write),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  logic [7:0]  mem [256];
  logic [7:0]  ref_mem [256];
  logic [15:0] fill_log [8];
  logic [15:0] wr_addr;
  int rd_cnt = 0, wr_cnt = 0;
  int total = 0, fails = 0;

  initial for (int i = 0; i < 256; i++) begin
    mem[i]     = 8'(i * 37 + 11);
    ref_mem[i] = 8'(i * 37 + 11);
  end

  always @(negedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[7:0]];
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        wr_addr <= mem_addr;
        wr_cnt  <= wr_cnt + 1;
      end else begin
        if (rd_cnt < 8) fill_log[rd_cnt] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end else mem_ack <= 1'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [15:0] addr, input logic [7:0] wd,
                        output logic [7:0] rd);
    bit seen = 0;
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      if (cpu_done) seen = 1;
      else @(negedge clk);
    end
    check(seen, "R11", int'(seen), 1);
    rd = cpu_rdata;
    if (we) ref_mem[addr[7:0]] = wd;
  endtask

  task automatic t_reset;
    check(cpu_ready == 1'b1, "R2", int'(cpu_ready), 1);
    check(cpu_done == 1'b0, "R2", int'(cpu_done), 0);
    check(mem_req == 1'b0, "R2", int'(mem_req), 0);
  endtask

  task automatic t_map;
    logic [7:0] rd;
    access(0, 16'h003A, 8'h00, rd);
    check(rd_cnt == 4, "R2", rd_cnt, 4);
    for (int i = 0; i < 4; i++)
      check(fill_log[i] == 16'h0038 + 16'(i), "R4", int'(fill_log[i]), 16'h38 + i);
    check(rd == ref_mem[8'h3A], "R4", int'(rd), int'(ref_mem[8'h3A]));
    access(0, 16'h0039, 8'h00, rd);
    check(rd_cnt == 0, "R3", rd_cnt, 0);
    check(rd == ref_mem[8'h39], "R3", int'(rd), int'(ref_mem[8'h39]));
    access(0, 16'h0034, 8'h00, rd);
    check(rd_cnt == 4, "R1", rd_cnt, 4);
    access(0, 16'h003B, 8'h00, rd);
    check(rd_cnt == 0, "R1", rd_cnt, 0);
    check(rd == ref_mem[8'h3B], "R1", int'(rd), int'(ref_mem[8'h3B]));
  endtask

  task automatic t_evict;
    logic [7:0] rd;
    access(0, 16'h002A, 8'h00, rd);
    check(rd_cnt == 4, "R5", rd_cnt, 4);
    check(rd == ref_mem[8'h2A], "R5", int'(rd), int'(ref_mem[8'h2A]));
    access(0, 16'h0038, 8'h00, rd);
    check(rd_cnt == 4, "R5", rd_cnt, 4);
    check(rd == ref_mem[8'h38], "R5", int'(rd), int'(ref_mem[8'h38]));
  endtask

  task automatic t_write_hit;
    logic [7:0] rd;
    alloc_on_write = 1'b0;
    access(1, 16'h0039, 8'hA5, rd);
    check(rd_cnt == 0, "R7", rd_cnt, 0);
    check(wr_cnt == 1, "R6", wr_cnt, 1);
    check(wr_addr == 16'h0039, "R6", int'(wr_addr), 16'h39);
    check(mem[8'h39] == 8'hA5, "R6", int'(mem[8'h39]), 8'hA5);
    access(0, 16'h0039, 8'h00, rd);
    check(rd_cnt == 0, "R7", rd_cnt, 0);
    check(rd == 8'hA5, "R7", int'(rd), 8'hA5);
  endtask

  task automatic t_alloc;
    logic [7:0] rd;
    alloc_on_write = 1'b1;
    access(1, 16'h0047, 8'h5C, rd);
    check(rd_cnt == 4, "R8", rd_cnt, 4);
    check(wr_cnt == 1, "R6", wr_cnt, 1);
    access(0, 16'h0047, 8'h00, rd);
    check(rd_cnt == 0, "R8", rd_cnt, 0);
    check(rd == 8'h5C, "R8", int'(rd), 8'h5C);
    access(0, 16'h0044, 8'h00, rd);
    check(rd == ref_mem[8'h44], "R8", int'(rd), int'(ref_mem[8'h44]));
    alloc_on_write = 1'b0;
  endtask

  task automatic t_noalloc;
    logic [7:0] rd;
    alloc_on_write = 1'b0;
    access(0, 16'h0010, 8'h00, rd);
    access(1, 16'h0002, 8'h77, rd);
    check(rd_cnt == 0, "R9", rd_cnt, 0);
    check(wr_cnt == 1, "R9", wr_cnt, 1);
    check(mem[8'h02] == 8'h77, "R9", int'(mem[8'h02]), 8'h77);
    access(0, 16'h0010, 8'h00, rd);
    check(rd_cnt == 0, "R9", rd_cnt, 0);
    check(rd == ref_mem[8'h10], "R9", int'(rd), int'(ref_mem[8'h10]));
    access(0, 16'h0002, 8'h00, rd);
    check(rd_cnt == 4, "R9", rd_cnt, 4);
    check(rd == 8'h77, "R9", int'(rd), 8'h77);
  endtask

  task automatic t_handshake;
    logic [7:0] rd;
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h00C1;
    @(negedge clk);
    cpu_req = 1'b0;
    check(cpu_ready == 1'b0, "R10", int'(cpu_ready), 0);
    while (!cpu_done) @(negedge clk);
    rd = cpu_rdata;
    check(rd == ref_mem[8'hC1], "R4", int'(rd), int'(ref_mem[8'hC1]));
    @(negedge clk);
    check(cpu_done == 1'b0, "R11", int'(cpu_done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_evict();
    t_write_hit();
    t_alloc();
    t_noalloc();
    t_handshake();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(20 * 100000);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule